// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches one asynchronous serial line, optionally inverted, and reports two conditions on it. Both are measured against the duration of one complete character frame. The frame duration is set by the character configuration: data width, parity enable, stop length and the bit period in clocks.

A break is a low stretch that lasts at least one frame duration. It is reported when the line returns high, together with the length of that low stretch in clocks. An idle is a high stretch that lasts one frame duration. The block reports it again for every further frame duration in which the line stays high.

A companion receiver may send two hints. One marks the end of a good character. The other marks a start bit that was sampled high and abandoned. Each hint restarts the idle window. The break pulse is meant to send that receiver back to searching for a start bit.

Top module: `line_cond_mon`

## Requirements
- R1: The frame duration in clocks is ceil(H * P / 2), where P is `cfg_clks_per_bit` and H = 2 + 2*`cfg_data_bits` + 2*`cfg_parity_en` + `cfg_stop_half`. `cfg_stop_half` gives the stop length in half-bit units, so 2 means one stop bit and 3 means one and a half.
- R2: When the line has been logically low for N consecutive clock samples, with N at least the frame duration, and then returns high, `brk_pulse` is high for exactly one cycle and `brk_len` carries N.
- R3: A low stretch one sample shorter than the frame duration produces no break pulse.
- R4: The low-duration counter saturates at its all-ones value of `CNT_W` bits. A very long low stretch therefore reports the maximum and never a wrapped small value.
- R5: After F consecutive high samples, where F is the frame duration, `idle_pulse` is high for one cycle and the measurement restarts. A high stretch of H samples gives floor(H/F) idle pulses.
- R6: Any low sample cancels the idle measurement in progress. Two high stretches separated by a short low stretch are never added together.
- R7: A one-cycle `rx_frame_done` while the line is high discards the accumulated high time. The next idle pulse comes F high samples after the hint.
- R8: A one-cycle `rx_start_abort` while the line is high discards the accumulated high time and skips the next ceil(P/2) high samples, half a bit time. The idle pulse follows after F further high samples.
- R9: With `line_inv` set to 1, the logical level is the inverse of `rx_line`. A physically high stretch is then measured as a break.
- R10: While reset is asserted, and on the first cycle after it, `brk_pulse` and `idle_pulse` are 0 and `brk_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial line, already in the clock domain |
| line_inv | input | 1 | 1 inverts the line polarity |
| cfg_data_bits | input | DBITS_W | Data bits per character |
| cfg_parity_en | input | 1 | 1 when a parity bit is present |
| cfg_stop_half | input | STOP_W | Stop length in half-bit units |
| cfg_clks_per_bit | input | CPB_W | Bit period in clocks |
| rx_frame_done | input | 1 | Receiver hint: a good character ended here |
| rx_start_abort | input | 1 | Receiver hint: start bit sampled high and abandoned |
| brk_pulse | output | 1 | One-cycle break report |
| brk_len | output | CNT_W | Measured low duration of the last break, in clocks |
| idle_pulse | output | 1 | One-cycle idle report |

## Verification
Low stretches of F-1, F, and far more than the counter can hold separate a missing threshold, an off-by-one threshold and a counter that wraps. High stretches of 30, then a short low, then 30 more check that a low cancels the idle measurement. A stretch of 85 checks that idle reports repeat at 2F without drift. In two high stretches, a frame-done hint or an abort hint is placed so that the expected idle count differs from the count with no hint. For the abort, stretches of F+1 and F+2 samples after the hint also check that the skip is exactly half a bit. A second configuration with parity, one and a half stop bits and an odd bit period gives a frame length of 26. Its idle and break counts fail if the half-bit rounding goes the wrong way. Inverted polarity is checked by measuring a physically high stretch as a break.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  // width of the frame length expressed in half-bit units
  localparam int HALVES_W = 6;
  typedef logic [HALVES_W-1:0] halves_t;

  // frame length in half bits: start + data + parity + stop
  function automatic halves_t frame_halves(input halves_t dbits,
                                           input logic    par_en,
                                           input halves_t stop_h);
    halves_t par_h;
    par_h = par_en ? halves_t'(2) : halves_t'(0);
    return halves_t'(2) + (dbits << 1) + par_h + stop_h;
  endfunction
endpackage

// File: rtl/lcm_frame_len.sv
module lcm_frame_len #(
  parameter int CPB_W = 16,
  parameter int FL_W  = lcm_pkg::HALVES_W + CPB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  lcm_pkg::halves_t      dbits,
  input  logic                  par_en,
  input  lcm_pkg::halves_t      stop_h,
  input  logic [CPB_W-1:0]      cpb,
  output logic [FL_W-1:0]       flen
);
  lcm_pkg::halves_t  halves;
  logic [FL_W-1:0]   prod;
  logic [FL_W:0]     prod_rnd;

  always_comb begin
    halves   = lcm_pkg::frame_halves(dbits, par_en, stop_h);
    prod     = FL_W'(halves) * FL_W'(cpb);
    prod_rnd = {1'b0, prod} + (FL_W+1)'(1);
  end

  // half-unit product rounded up to whole clocks
  always_ff @(posedge clk) begin
    if (rst) flen <= '0;
    else     flen <= prod_rnd[FL_W:1];
  end
endmodule

// File: rtl/lcm_low_timer.sv
module lcm_low_timer #(
  parameter int CNT_W = 24,
  parameter int FL_W  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             lvl_prev,
  input  logic [FL_W-1:0]  flen,
  output logic             brk_pulse,
  output logic [CNT_W-1:0] brk_len
);
  localparam int CMP_W = (CNT_W > FL_W) ? CNT_W : FL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_cnt;
  logic             long_enough;

  always_comb long_enough = CMP_W'(low_cnt) >= CMP_W'(flen);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      brk_pulse <= 1'b0;
      brk_len   <= '0;
    end else begin
      brk_pulse <= 1'b0;
      if (!lvl) begin
        if (lvl_prev)               low_cnt <= CNT_W'(1);
        else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + CNT_W'(1);
      end else if (!lvl_prev) begin
        if (long_enough) begin
          brk_pulse <= 1'b1;
          brk_len   <= low_cnt;
        end
        low_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/lcm_high_timer.sv
module lcm_high_timer #(
  parameter int CPB_W = 16,
  parameter int FL_W  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             frame_done,
  input  logic             start_abort,
  input  logic [CPB_W-1:0] cpb,
  input  logic [FL_W-1:0]  flen,
  output logic             idle_pulse
);
  logic [FL_W-1:0]  hi_cnt;
  logic [FL_W:0]    nxt;
  logic [CPB_W-1:0] hold;
  logic [CPB_W:0]   cpb_p1;
  logic [CPB_W-1:0] half_bit;
  logic             armed;

  always_comb begin
    nxt      = {1'b0, hi_cnt} + (FL_W+1)'(1);
    cpb_p1   = {1'b0, cpb} + (CPB_W+1)'(1);
    half_bit = cpb_p1[CPB_W:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt     <= '0;
      hold       <= '0;
      armed      <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= 1'b0;
      if (!lvl) begin
        armed  <= 1'b0;
        hi_cnt <= '0;
        hold   <= '0;
      end else if (frame_done) begin
        armed  <= 1'b1;
        hi_cnt <= '0;
        hold   <= '0;
      end else if (start_abort) begin
        armed  <= 1'b1;
        hi_cnt <= '0;
        hold   <= half_bit;
      end else if (hold != '0) begin
        hold <= hold - CPB_W'(1);
      end else if (!armed) begin
        armed  <= 1'b1;
        hi_cnt <= FL_W'(1);
      end else if (nxt >= {1'b0, flen}) begin
        idle_pulse <= 1'b1;
        hi_cnt     <= '0;
      end else begin
        hi_cnt <= nxt[FL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/line_cond_mon.sv
module line_cond_mon #(
  parameter int CPB_W   = 16,
  parameter int CNT_W   = 24,
  parameter int DBITS_W = 4,
  parameter int STOP_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_line,
  input  logic               line_inv,
  input  logic [DBITS_W-1:0] cfg_data_bits,
  input  logic               cfg_parity_en,
  input  logic [STOP_W-1:0]  cfg_stop_half,
  input  logic [CPB_W-1:0]   cfg_clks_per_bit,
  input  logic               rx_frame_done,
  input  logic               rx_start_abort,
  output logic               brk_pulse,
  output logic [CNT_W-1:0]   brk_len,
  output logic               idle_pulse
);
  localparam int FL_W = lcm_pkg::HALVES_W + CPB_W;

  logic            lvl_q, lvl_prev, done_q, abort_q;
  logic [FL_W-1:0] flen_clks;

  // input stage: polarity fix, edge history and hints kept in step
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= 1'b1;
      lvl_prev <= 1'b1;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      lvl_q    <= rx_line ^ line_inv;
      lvl_prev <= lvl_q;
      done_q   <= rx_frame_done;
      abort_q  <= rx_start_abort;
    end
  end

  lcm_frame_len #(.CPB_W(CPB_W), .FL_W(FL_W)) u_flen (
    .clk    (clk),
    .rst    (rst),
    .dbits  (lcm_pkg::halves_t'(cfg_data_bits)),
    .par_en (cfg_parity_en),
    .stop_h (lcm_pkg::halves_t'(cfg_stop_half)),
    .cpb    (cfg_clks_per_bit),
    .flen   (flen_clks)
  );

  lcm_low_timer #(.CNT_W(CNT_W), .FL_W(FL_W)) u_low (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl_q),
    .lvl_prev  (lvl_prev),
    .flen      (flen_clks),
    .brk_pulse (brk_pulse),
    .brk_len   (brk_len)
  );

  lcm_high_timer #(.CPB_W(CPB_W), .FL_W(FL_W)) u_high (
    .clk         (clk),
    .rst         (rst),
    .lvl         (lvl_q),
    .frame_done  (done_q),
    .start_abort (abort_q),
    .cpb         (cfg_clks_per_bit),
    .flen        (flen_clks),
    .idle_pulse  (idle_pulse)
  );
endmodule

// File: rtl/lcm_chk.sv
module lcm_chk #(
  parameter int CNT_W = 24,
  parameter int FL_W  = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             brk_pulse,
  input logic [CNT_W-1:0] brk_len,
  input logic             idle_pulse,
  input logic [FL_W-1:0]  flen,
  input logic             lvl
);
  localparam int CMP_W = (CNT_W > FL_W) ? CNT_W : FL_W;

  // R2
  brk_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |=> !brk_pulse);

  // R3
  brk_len_min_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> CMP_W'(brk_len) >= CMP_W'($past(flen)));

  // R4
  brk_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_pulse |-> $stable(brk_len));

  // R5
  idle_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |=> !idle_pulse);

  // R6
  idle_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |-> $past(lvl));

  // R2
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(brk_pulse && idle_pulse));
endmodule

bind line_cond_mon lcm_chk #(.CNT_W(CNT_W), .FL_W(FL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .brk_pulse  (brk_pulse),
  .brk_len    (brk_len),
  .idle_pulse (idle_pulse),
  .flen       (flen_clks),
  .lvl        (lvl_q)
);

// File: tb/sim_line_cond_mon.sv
`timescale 1ns/1ps
module sim_line_cond_mon;
  localparam int CPB_W = 8;
  localparam int CNT_W = 8;
  localparam int SAT   = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b0;
  logic line_inv = 1'b0;
  logic [3:0] cfg_data_bits = 4'd8;
  logic cfg_parity_en = 1'b0;
  logic [2:0] cfg_stop_half = 3'd2;
  logic [CPB_W-1:0] cfg_clks_per_bit = 8'd4;
  logic rx_frame_done = 1'b0;
  logic rx_start_abort = 1'b0;
  logic brk_pulse, idle_pulse;
  logic [CNT_W-1:0] brk_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    is_brk;
    int    len;
    string req;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  line_cond_mon #(.CPB_W(CPB_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .line_inv(line_inv),
    .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_stop_half(cfg_stop_half), .cfg_clks_per_bit(cfg_clks_per_bit),
    .rx_frame_done(rx_frame_done), .rx_start_abort(rx_start_abort),
    .brk_pulse(brk_pulse), .brk_len(brk_len), .idle_pulse(idle_pulse)
  );

  // frame length from the R1 formula
  function automatic int frame_clks(int db, int par, int sh, int cpb);
    return ((2 + 2*db + 2*par + sh) * cpb + 1) / 2;
  endfunction

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_idle(int n, string req);
    for (int i = 0; i < n; i++) expq.push_back('{1'b0, 0, req});
  endtask

  // monitor: pops expected events as the design reports them
  task automatic take_event(bit is_brk, int len);
    exp_t e;
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL unexpected: actual kind=%0d len=%0d expected=none", is_brk, len);
    end else begin
      e = expq.pop_front();
      if (e.is_brk != is_brk || (is_brk && e.len != len)) begin
        fails++;
        $display("FAIL %s: actual kind=%0d len=%0d expected kind=%0d len=%0d",
                 e.req, is_brk, len, e.is_brk, e.len);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (brk_pulse)  take_event(1'b1, int'(brk_len));
      if (idle_pulse) take_event(1'b0, 0);
    end
  end

  task automatic seg_low(int n, int f, string req);
    rx_line = line_inv ? 1'b1 : 1'b0;
    repeat (n) @(posedge clk);
    #1;
    if (n >= f) expq.push_back('{1'b1, (n > SAT) ? SAT : n, req});
  endtask

  task automatic seg_high(int n, int f, string req);
    rx_line = line_inv ? 1'b0 : 1'b1;
    push_idle(n / f, req);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // high stretch with a hint after p samples, then q more samples
  task automatic seg_hint(int p, int q, bit abort, int skip, int f, string req);
    rx_line = line_inv ? 1'b0 : 1'b1;
    push_idle(p / f, req);
    push_idle((q - skip) / f, req);
    repeat (p) @(posedge clk);
    #1;
    if (abort) rx_start_abort = 1'b1; else rx_frame_done = 1'b1;
    @(posedge clk);
    #1;
    rx_start_abort = 1'b0;
    rx_frame_done  = 1'b0;
    repeat (q) @(posedge clk);
    #1;
  endtask

  initial begin
    int f1, f2;
    f1 = frame_clks(8, 0, 2, 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_val("R10 brk_pulse", int'(brk_pulse), 0);
    check_val("R10 idle_pulse", int'(idle_pulse), 0);
    check_val("R10 brk_len", int'(brk_len), 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    seg_low(5, f1, "warmup");
    seg_high(30, f1, "R6");
    seg_low(3, f1, "R6");
    seg_high(30, f1, "R6");
    seg_low(f1 - 1, f1, "R3");
    seg_high(85, f1, "R5");
    seg_low(f1, f1, "R2");
    seg_high(45, f1, "R5");
    seg_low(300, f1, "R4");
    seg_high(10, f1, "R4");
    seg_low(5, f1, "R7");
    seg_hint(30, 79, 1'b0, 0, f1, "R7");
    seg_low(5, f1, "R8");
    seg_hint(30, 41, 1'b1, 2, f1, "R8");
    seg_low(5, f1, "R8");
    seg_hint(30, 42, 1'b1, 2, f1, "R8");
    seg_low(5, f1, "R9");
    line_inv = 1'b1;
    seg_high(40, f1, "R9");
    seg_low(41, f1, "R9");
    seg_high(10, f1, "R9");
    line_inv = 1'b0;
    seg_low(5, f1, "R1");
    // second format: 5 data, parity, 1.5 stop, 3 clocks per bit
    cfg_data_bits    = 4'd5;
    cfg_parity_en    = 1'b1;
    cfg_stop_half    = 3'd3;
    cfg_clks_per_bit = 8'd3;
    f2 = frame_clks(5, 1, 3, 3);
    seg_high(10, f2, "R1");
    seg_low(f2 - 1, f2, "R1");
    seg_high(f2, f2, "R1");
    seg_low(f2, f2, "R1");
    seg_high(52, f2, "R1");
    seg_low(5, f2, "R1");
    repeat (20) @(posedge clk);
    #1;
    check_val("R2 all expected events seen", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule